// File: doc/BRIEF.md
# Shared RAM Read-Port Arbiter with Deferred CPU Read

This block lets two read requesters, a CPU and a DMA engine, share the single read port of a synchronous RAM. The RAM sits outside the block. It takes an enable and an address in one cycle and returns the word on the next cycle. The block chooses which address goes to the RAM each cycle. When the word comes back, the block sends it to the requester that owns it, together with that requester's own valid pulse.

DMA has absolute priority and is never delayed. If the CPU asks in the same cycle as the DMA, the CPU's address is parked in a one-entry slot. That read is issued on the first cycle in which the DMA is not reading. The CPU's valid stays low until its own word returns, so a collision never loses the CPU request and never gives the CPU the DMA's data.

The CPU side follows a request-then-wait discipline: it issues one read and waits for its valid before it issues the next. The block relies on this, and a simulation-only assertion catches any CPU request that arrives while the slot is full.

Top module: `shared_ram_arbiter`

## Requirements
- R1: Whenever `dma_req` is high, `ram_en` is high in the same cycle and `ram_addr` equals `dma_addr`, whatever the CPU side is doing.
- R2: When `cpu_req` and `dma_req` are both high in one cycle, the CPU address is held in a pending slot, and `cpu_valid` stays low on the following cycle.
- R3: A pending CPU read is presented on `ram_addr`, with `ram_en` high, in the first later cycle in which `dma_req` is low. The slot then empties. A CPU request arriving while the slot is full is a protocol violation that a simulation-only assertion reports.
- R4: `cpu_valid` and `dma_valid` are never high together. When one of them is high, the matching data output carries the RAM word read at the address that requester supplied. Each valid is a single-cycle pulse per read.
- R5: In a collision followed by an idle cycle, `dma_valid` pulses on the cycle after the request and `cpu_valid` pulses one cycle after that.
- R6: A CPU request with no DMA request and an empty slot drives `cpu_valid` high on the next cycle.
- R7: A DMA request drives `dma_valid` high on the next cycle and produces no `cpu_valid` pulse.
- R8: While `dma_req` stays high on consecutive cycles, a pending CPU read waits. It is issued in the first cycle without a DMA request and completes on the cycle after that.
- R9: Synchronous reset empties the pending slot, and `cpu_valid` and `dma_valid` are low in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU read request strobe, one cycle per read |
| cpu_addr | input | ADDR_W | CPU read address |
| dma_req | input | 1 | DMA read request strobe |
| dma_addr | input | ADDR_W | DMA read address |
| ram_en | output | 1 | Read enable to the RAM |
| ram_addr | output | ADDR_W | Read address to the RAM |
| ram_rdata | input | DATA_W | RAM read word, valid one cycle after `ram_en` |
| cpu_valid | output | 1 | One-cycle pulse: `cpu_rdata` holds the CPU word |
| cpu_rdata | output | DATA_W | CPU read data, zero when not valid |
| dma_valid | output | 1 | One-cycle pulse: `dma_rdata` holds the DMA word |
| dma_rdata | output | DATA_W | DMA read data, zero when not valid |

## Verification
The two functions that can land in the same cycle are the DMA grant and the CPU request. A third case is the DMA grant and the issue of a parked CPU read. Directed phases provoke each one by raising both strobes in one cycle, or by holding `dma_req` high across a parked read. A protocol-respecting pseudo-random phase then mixes all of them. The bench holds its own RAM model and an independent queue-based prediction of every valid pulse and data word. It judges each cycle on the RAM address issued, on which requester receives the word, and on whether that word matches the address the requester asked for.

// File: rtl/ram_arb_pkg.sv
package ram_arb_pkg;

    // Which requester owns the word coming back from the RAM next cycle.
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_CPU  = 2'd1,
        OWN_DMA  = 2'd2
    } owner_e;

    // Decision taken by the grant logic in one cycle.
    typedef struct packed {
        logic   issue;     // RAM read issued this cycle
        logic   from_slot; // issued address came from the parked CPU slot
        owner_e owner;     // requester that owns the word
    } grant_t;

    function automatic logic owner_is(owner_e tag, owner_e who);
        return tag == who;
    endfunction

endpackage

// File: rtl/rarb_pend_slot.sv
module rarb_pend_slot
    import ram_arb_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              dma_req,
    output logic              pend_v,
    output logic [ADDR_W-1:0] pend_addr
);

    logic park;
    logic drain;

    // Park the CPU address only when the DMA takes the port and the slot is free.
    assign park  = cpu_req && dma_req && !pend_v;
    // The parked read leaves on the first cycle with no DMA request.
    assign drain = pend_v && !dma_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v    <= 1'b0;
            pend_addr <= '0;
        end else begin
            if (park) begin
                pend_v    <= 1'b1;
                pend_addr <= cpu_addr;
            end else if (drain) begin
                pend_v    <= 1'b0;
            end
        end
    end

    // R3: the client must wait for its valid, so no new CPU request may land on a full slot.
    assert_single_outstanding_R3: assert property (@(posedge clk) disable iff (rst)
        pend_v |-> !cpu_req);

    // R8: while DMA keeps reading, the parked entry and its address stay put.
    assert_slot_held_R8: assert property (@(posedge clk) disable iff (rst)
        (pend_v && dma_req) |=> (pend_v && $stable(pend_addr)));

endmodule

// File: rtl/rarb_grant.sv
module rarb_grant
    import ram_arb_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              dma_req,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic              pend_v,
    input  logic [ADDR_W-1:0] pend_addr,
    output logic              ram_en,
    output logic [ADDR_W-1:0] ram_addr,
    output grant_t            grant
);

    // Fixed priority: DMA, then the parked CPU read, then a fresh CPU read.
    always_comb begin
        grant    = '{issue: 1'b0, from_slot: 1'b0, owner: OWN_NONE};
        ram_addr = '0;
        if (dma_req) begin
            grant.issue = 1'b1;
            grant.owner = OWN_DMA;
            ram_addr    = dma_addr;
        end else if (pend_v) begin
            grant.issue     = 1'b1;
            grant.from_slot = 1'b1;
            grant.owner     = OWN_CPU;
            ram_addr        = pend_addr;
        end else if (cpu_req) begin
            grant.issue = 1'b1;
            grant.owner = OWN_CPU;
            ram_addr    = cpu_addr;
        end
        ram_en = grant.issue;
    end

endmodule

// File: rtl/rarb_resp_steer.sv
module rarb_resp_steer
    import ram_arb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  grant_t            grant,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              cpu_valid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              dma_valid,
    output logic [DATA_W-1:0] dma_rdata
);

    owner_e owner_q;

    // Owner tag travels alongside the RAM's one-cycle read latency.
    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q <= OWN_NONE;
        end else begin
            owner_q <= grant.issue ? grant.owner : OWN_NONE;
        end
    end

    always_comb begin
        cpu_valid = owner_is(owner_q, OWN_CPU);
        dma_valid = owner_is(owner_q, OWN_DMA);
        cpu_rdata = cpu_valid ? ram_rdata : '0;
        dma_rdata = dma_valid ? ram_rdata : '0;
    end

    // R4: a returned word has exactly one destination.
    assert_valid_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(cpu_valid && dma_valid));

endmodule

// File: rtl/shared_ram_arbiter.sv
module shared_ram_arbiter
    import ram_arb_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              dma_req,
    input  logic [ADDR_W-1:0] dma_addr,
    output logic              ram_en,
    output logic [ADDR_W-1:0] ram_addr,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              cpu_valid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              dma_valid,
    output logic [DATA_W-1:0] dma_rdata
);

    logic              pend_v;
    logic [ADDR_W-1:0] pend_addr;
    grant_t            grant;

    rarb_pend_slot #(.ADDR_W(ADDR_W)) u_slot (
        .clk       (clk),
        .rst       (rst),
        .cpu_req   (cpu_req),
        .cpu_addr  (cpu_addr),
        .dma_req   (dma_req),
        .pend_v    (pend_v),
        .pend_addr (pend_addr)
    );

    rarb_grant #(.ADDR_W(ADDR_W)) u_grant (
        .cpu_req   (cpu_req),
        .cpu_addr  (cpu_addr),
        .dma_req   (dma_req),
        .dma_addr  (dma_addr),
        .pend_v    (pend_v),
        .pend_addr (pend_addr),
        .ram_en    (ram_en),
        .ram_addr  (ram_addr),
        .grant     (grant)
    );

    rarb_resp_steer #(.DATA_W(DATA_W)) u_steer (
        .clk       (clk),
        .rst       (rst),
        .grant     (grant),
        .ram_rdata (ram_rdata),
        .cpu_valid (cpu_valid),
        .cpu_rdata (cpu_rdata),
        .dma_valid (dma_valid),
        .dma_rdata (dma_rdata)
    );

    // R1: DMA is granted in its own cycle, regardless of the CPU side.
    assert_dma_first_R1: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> (ram_en && ram_addr == dma_addr));

    // R2: a collision parks the CPU address and withholds CPU valid next cycle.
    assert_collision_park_R2: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && dma_req && !pend_v) |=> (pend_v && pend_addr == $past(cpu_addr) && !cpu_valid));

    // R3: the parked read goes out on the first DMA-free cycle.
    assert_slot_issue_R3: assert property (@(posedge clk) disable iff (rst)
        (pend_v && !dma_req) |-> (ram_en && ram_addr == pend_addr));

    // R6: an uncontended CPU read completes on the next cycle.
    assert_cpu_solo_R6: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !dma_req && !pend_v) |=> cpu_valid);

    // R7: a DMA read always completes on the next cycle to the DMA side.
    assert_dma_return_R7: assert property (@(posedge clk) disable iff (rst)
        dma_req |=> (dma_valid && !cpu_valid));

    // R9: nothing is returned in the cycle after reset.
    assert_reset_quiet_R9: assert property (@(posedge clk)
        rst |=> (!cpu_valid && !dma_valid));

endmodule

// File: tb/tb_shared_ram_arbiter.sv
`timescale 1ns/1ps
module tb_shared_ram_arbiter;

    localparam int AW = 10;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_req = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          dma_req = 1'b0;
    logic [AW-1:0] dma_addr = '0;
    logic          ram_en;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_rdata;
    logic          cpu_valid;
    logic [DW-1:0] cpu_rdata;
    logic          dma_valid;
    logic [DW-1:0] dma_rdata;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string tag = "R9";

    always #5 clk = ~clk;

    shared_ram_arbiter #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .dma_req(dma_req), .dma_addr(dma_addr),
        .ram_en(ram_en), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
        .cpu_valid(cpu_valid), .cpu_rdata(cpu_rdata),
        .dma_valid(dma_valid), .dma_rdata(dma_rdata)
    );

    function automatic logic [DW-1:0] pat(logic [AW-1:0] a);
        return (32'(a) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    // RAM model: registered read, content computed from the address.
    always_ff @(posedge clk) begin
        if (ram_en) ram_rdata <= pat(ram_addr);
    end

    // Reference model state
    logic [AW-1:0] parked[$];
    bit            exp_cpu_v = 0, exp_dma_v = 0;
    logic [DW-1:0] exp_cpu_d = '0, exp_dma_d = '0;
    bit            cpu_busy = 0;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Compare the outputs produced by the last edge with the model's prediction.
    task automatic compare_outputs();
        chk(tag, "cpu_valid", 64'(cpu_valid), 64'(exp_cpu_v));
        chk(tag, "dma_valid", 64'(dma_valid), 64'(exp_dma_v));
        chk("R4", "valid exclusive", 64'(cpu_valid && dma_valid), 64'd0);
        if (exp_cpu_v) chk("R4", "cpu_rdata", 64'(cpu_rdata), 64'(exp_cpu_d));
        if (exp_dma_v) chk("R4", "dma_rdata", 64'(dma_rdata), 64'(exp_dma_d));
        if (cpu_valid) cpu_busy = 0;
    endtask

    // One cycle: at the falling edge, check, drive, predict, check the RAM port.
    task automatic step(bit c, logic [AW-1:0] ca, bit d, logic [AW-1:0] da);
        bit            iss;
        logic [AW-1:0] ia;
        @(negedge clk);
        compare_outputs();
        cpu_req = c; cpu_addr = ca; dma_req = d; dma_addr = da;
        if (c) cpu_busy = 1;
        exp_cpu_v = 0; exp_dma_v = 0; iss = 0; ia = '0;
        if (d) begin
            iss = 1; ia = da; exp_dma_v = 1; exp_dma_d = pat(da);
            if (c) parked.push_back(ca);
        end else if (parked.size() > 0) begin
            iss = 1; ia = parked.pop_front(); exp_cpu_v = 1; exp_cpu_d = pat(ia);
        end else if (c) begin
            iss = 1; ia = ca; exp_cpu_v = 1; exp_cpu_d = pat(ca);
        end
        #1;
        chk(d ? "R1" : "R3", "ram_en", 64'(ram_en), 64'(iss));
        if (iss) chk(d ? "R1" : "R3", "ram_addr", 64'(ram_addr), 64'(ia));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, '0, 0, '0);
    endtask

    initial begin : watchdog
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R9: first cycle after reset returns nothing.
        @(negedge clk);
        chk("R9", "cpu_valid after reset", 64'(cpu_valid), 64'd0);
        chk("R9", "dma_valid after reset", 64'(dma_valid), 64'd0);
        chk("R9", "ram_en idle after reset", 64'(ram_en), 64'd0);

        tag = "R6";
        step(1, 10'h011, 0, '0);
        idle(2);
        step(1, 10'h3FF, 0, '0);
        idle(2);

        tag = "R7";
        step(0, '0, 1, 10'h022);
        idle(2);
        step(0, '0, 1, 10'h000);
        step(0, '0, 1, 10'h001);
        idle(2);

        tag = "R2";
        step(1, 10'h0A0, 1, 10'h0B0);
        tag = "R5";
        step(0, '0, 0, '0);
        idle(2);

        tag = "R8";
        step(1, 10'h1C1, 1, 10'h2D0);
        for (int i = 1; i < 5; i++) step(0, '0, 1, AW'(10'h2D0 + i));
        idle(3);

        // Collision, then DMA resumes right after the parked read issues.
        tag = "R3";
        step(1, 10'h155, 1, 10'h0AA);
        step(0, '0, 0, '0);
        step(0, '0, 1, 10'h0AB);
        idle(2);

        // Protocol-respecting mixed traffic.
        tag = "R4";
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            bit wc, wd;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            wd = lfsr[0] | lfsr[1];
            wc = lfsr[2] && !cpu_busy && parked.size() == 0;
            step(wc, lfsr[12:3], wd, lfsr[15:6]);
        end
        idle(4);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule